// File: doc/BRIEF.md
# Serial-Access Flash Read Port

This block is the memory-side serial interface of a small on-chip user flash array, limited to reading. A 512-word by 16-bit storage array sits behind two independent shift registers. The first is a 9-bit address register with its own clock. The second is a 16-bit data register with its own clock. A host selects a word by clocking its address in serially, or lets the address step forward by itself. It then loads the word into the data register and clocks it out one bit at a time, most significant bit first.

The storage is an ordinary register array, filled through a parallel initialization port on a third clock. That port exists for test and bring-up. Either serial clock can simply be stopped. A stopped clock freezes its register, so the host paces the whole access through the two clocks. Continuous streaming needs no reload of the address: the address register advances by one, wrapping at the top of the array, before each new word is loaded.

Top module: `uflash_read_port`

## Requirements
- R1: While `rst_n` is low, the address register and the data register are cleared asynchronously. After release, `data_sdo` is 0 and an unloaded-address read returns word 0.
- R2: On a rising `addr_clk` edge with `addr_shift_en` high, the address shifts left by one and `addr_sdi` enters bit 0. Nine such edges therefore load an address sent most significant bit first.
- R3: On a rising `addr_clk` edge with `addr_shift_en` low, the address increments by one. It wraps from 511 to 0.
- R4: With no `addr_clk` edge, the address holds, whatever `addr_sdi` and `addr_shift_en` do.
- R5: On a rising `data_clk` edge with `data_load_n` low, the data register takes the stored word at the current address in parallel. `data_sdo` then shows bit 15 of that word at once. A load also restarts a partly shifted word.
- R6: On a rising `data_clk` edge with `data_load_n` high, the data register shifts toward bit 15 and a 0 enters bit 0. After one load and 15 shifts, all 16 bits have appeared on `data_sdo`, most significant bit first. Any further shift shows 0.
- R7: With no `data_clk` edge, the data register and `data_sdo` hold their value.
- R8: On a rising `init_clk` edge with `init_we` high, `init_data` is written to word `init_addr` of the array. Later reads of that word return the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each clock domain |
| init_clk | input | 1 | Clock of the parallel initialization port |
| init_we | input | 1 | Write strobe of the initialization port |
| init_addr | input | 9 | Word index written by the initialization port |
| init_data | input | 16 | Word value written by the initialization port |
| addr_clk | input | 1 | Address register clock |
| addr_shift_en | input | 1 | High: shift address in serially; low: increment address |
| addr_sdi | input | 1 | Serial address bit |
| data_clk | input | 1 | Data register clock |
| data_load_n | input | 1 | Low: parallel load from array; high: shift out |
| data_sdo | output | 1 | Serial data output, bit 15 of the data register |

## Verification
The hardest situations to reach are the ones where the two serial clocks act apart from each other. One is an address that changes while a word is partly shifted out. Another is a clock that stops for many cycles while its control inputs keep moving. The bench drives each serial clock as single pulses from tasks. Between pulses it idles and toggles the unclocked controls, and it reloads words in the middle of a shift. An increment issued from address 511 exercises the wrap. A behavioural model updated on every pulse is compared with `data_sdo` on every bench clock.

// File: rtl/uflash_pkg.sv
package uflash_pkg;
  parameter int unsigned WORD_W = 16;
  parameter int unsigned DEPTH  = 512;
  localparam int unsigned AW    = $clog2(DEPTH);
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [AW-1:0]     waddr_t;
endpackage

// File: rtl/uflash_rst_sync.sv
module uflash_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;
endmodule

// File: rtl/uflash_addr_reg.sv
module uflash_addr_reg
  import uflash_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   shift_en,
  input  logic   sdi,
  output waddr_t addr
);
  waddr_t addr_q;
  waddr_t addr_d;

  always_comb begin
    if (shift_en) addr_d = {addr_q[AW-2:0], sdi};
    else          addr_d = addr_q + waddr_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/uflash_array.sv
module uflash_array
  import uflash_pkg::*;
(
  input  logic   wr_clk,
  input  logic   wr_en,
  input  waddr_t wr_addr,
  input  word_t  wr_data,
  input  waddr_t rd_addr,
  output word_t  rd_data
);
  word_t store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  assign rd_data = store[rd_addr];
endmodule

// File: rtl/uflash_data_reg.sv
module uflash_data_reg
  import uflash_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_n,
  input  word_t par_in,
  output word_t word,
  output logic  sdo
);
  word_t dreg_q;
  word_t dreg_d;

  always_comb begin
    if (!load_n) dreg_d = par_in;
    else         dreg_d = {dreg_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dreg_q <= '0;
    else        dreg_q <= dreg_d;
  end

  assign word = dreg_q;
  assign sdo  = dreg_q[WORD_W-1];
endmodule

// File: rtl/uflash_read_port.sv
module uflash_read_port
  import uflash_pkg::*;
(
  input  logic        rst_n,
  input  logic        init_clk,
  input  logic        init_we,
  input  logic [8:0]  init_addr,
  input  logic [15:0] init_data,
  input  logic        addr_clk,
  input  logic        addr_shift_en,
  input  logic        addr_sdi,
  input  logic        data_clk,
  input  logic        data_load_n,
  output logic        data_sdo
);
  logic   arst_n;
  logic   drst_n;
  waddr_t cur_addr;
  word_t  rd_word;
  word_t  dreg;

  uflash_rst_sync u_rs_a (.clk(addr_clk), .rst_n(rst_n), .rst_n_sync(arst_n));
  uflash_rst_sync u_rs_d (.clk(data_clk), .rst_n(rst_n), .rst_n_sync(drst_n));

  uflash_addr_reg u_addr (
    .clk(addr_clk), .rst_n(arst_n), .shift_en(addr_shift_en),
    .sdi(addr_sdi), .addr(cur_addr)
  );

  uflash_array u_arr (
    .wr_clk(init_clk), .wr_en(init_we), .wr_addr(init_addr),
    .wr_data(init_data), .rd_addr(cur_addr), .rd_data(rd_word)
  );

  uflash_data_reg u_data (
    .clk(data_clk), .rst_n(drst_n), .load_n(data_load_n),
    .par_in(rd_word), .word(dreg), .sdo(data_sdo)
  );
endmodule

// File: rtl/uflash_read_port_chk.sv
module uflash_read_port_chk (
  input logic        addr_clk,
  input logic        data_clk,
  input logic        arst_n,
  input logic        drst_n,
  input logic        addr_shift_en,
  input logic        addr_sdi,
  input logic        data_load_n,
  input logic        data_sdo,
  input logic [8:0]  cur_addr,
  input logic [15:0] rd_word,
  input logic [15:0] dreg
);
  a_r2_addr_shift: assert property (@(posedge addr_clk) disable iff (!arst_n)
    addr_shift_en |=> (cur_addr[0] == $past(addr_sdi)) && (cur_addr[8:1] == $past(cur_addr[7:0])));

  a_r3_addr_incr: assert property (@(posedge addr_clk) disable iff (!arst_n)
    !addr_shift_en |=> cur_addr == 9'($past(cur_addr) + 9'd1));

  a_r5_load: assert property (@(posedge data_clk) disable iff (!drst_n)
    !data_load_n |=> dreg == $past(rd_word));

  a_r6_shift_out: assert property (@(posedge data_clk) disable iff (!drst_n)
    data_load_n |=> data_sdo == $past(dreg[14]));

  a_r6_zero_fill: assert property (@(posedge data_clk) disable iff (!drst_n)
    data_load_n |=> !dreg[0]);
endmodule

bind uflash_read_port uflash_read_port_chk u_chk (
  .addr_clk(addr_clk), .data_clk(data_clk), .arst_n(arst_n), .drst_n(drst_n),
  .addr_shift_en(addr_shift_en), .addr_sdi(addr_sdi), .data_load_n(data_load_n),
  .data_sdo(data_sdo), .cur_addr(cur_addr), .rd_word(rd_word), .dreg(dreg)
);

// File: tb/uflash_read_port_test.sv
`timescale 1ns/1ps
module uflash_read_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        init_we = 1'b0;
  logic [8:0]  init_addr = '0;
  logic [15:0] init_data = '0;
  logic        addr_clk = 1'b0;
  logic        addr_shift_en = 1'b0;
  logic        addr_sdi = 1'b0;
  logic        data_clk = 1'b0;
  logic        data_load_n = 1'b1;
  logic        data_sdo;

  int compared = 0;
  int mismatched = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  logic [15:0] m_mem [512];
  int          m_addr = 0;
  logic [15:0] m_dreg = '0;

  always #10 clk = ~clk;

  uflash_read_port uut (
    .rst_n(rst_n), .init_clk(clk), .init_we(init_we), .init_addr(init_addr),
    .init_data(init_data), .addr_clk(addr_clk), .addr_shift_en(addr_shift_en),
    .addr_sdi(addr_sdi), .data_clk(data_clk), .data_load_n(data_load_n),
    .data_sdo(data_sdo)
  );

  function automatic logic [15:0] pat(input int i);
    return 16'((i * 40503 + 16'h1234) & 16'hFFFF);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) chk(data_sdo === m_dreg[15], "R7 per-clock sdo", int'(data_sdo), int'(m_dreg[15]));
  end

  task automatic apulse(input logic en, input logic b, input bit model);
    @(posedge clk); #2;
    addr_shift_en = en; addr_sdi = b;
    #3 addr_clk = 1'b1;
    if (model) begin
      if (en) m_addr = ((m_addr << 1) | int'(b)) & 511;
      else    m_addr = (m_addr + 1) & 511;
    end
    #5 addr_clk = 1'b0;
  endtask

  task automatic dpulse(input logic ld_n, input bit model);
    @(posedge clk); #2;
    data_load_n = ld_n;
    #3 data_clk = 1'b1;
    if (model) begin
      if (!ld_n) m_dreg = m_mem[m_addr];
      else       m_dreg = {m_dreg[14:0], 1'b0};
    end
    #5 data_clk = 1'b0;
  endtask

  task automatic load_addr(input int a);
    for (int b = 8; b >= 0; b--) apulse(1'b1, 1'((a >> b) & 1), 1'b1);
  endtask

  task automatic read_word(output logic [15:0] w);
    dpulse(1'b0, 1'b1);
    w[15] = data_sdo;
    for (int k = 14; k >= 0; k--) begin
      dpulse(1'b1, 1'b1);
      w[k] = data_sdo;
    end
  endtask

  task automatic init_write(input int a, input logic [15:0] v);
    @(posedge clk); #2;
    init_we = 1'b1; init_addr = 9'(a); init_data = v;
    m_mem[a] = v;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic        held;
    #1 rst_n = 1'b0;
    // R8: fill the array through the init port
    for (int i = 0; i < 512; i++) init_write(i, pat(i));
    @(posedge clk); #2 init_we = 1'b0;
    rst_n = 1'b1;
    // flush the per-domain reset synchronizers; registers stay cleared
    apulse(1'b0, 1'b0, 1'b0); apulse(1'b0, 1'b0, 1'b0);
    dpulse(1'b1, 1'b0); dpulse(1'b1, 1'b0);
    m_addr = 0; m_dreg = '0;
    cmp_on = 1'b1;
    #3 chk(data_sdo === 1'b0, "R1 sdo after reset", int'(data_sdo), 0);

    read_word(w);
    chk(w === pat(0), "R1 address cleared to 0", int'(w), int'(pat(0)));

    load_addr(5);
    read_word(w);
    chk(w === pat(5), "R2 serial address 5", int'(w), int'(pat(5)));

    load_addr(9'h1A3);
    read_word(w);
    chk(w === pat(9'h1A3), "R2 serial address 0x1A3", int'(w), int'(pat(9'h1A3)));

    apulse(1'b0, 1'b1, 1'b1);
    read_word(w);
    chk(w === pat(9'h1A4), "R3 stream increment", int'(w), int'(pat(9'h1A4)));

    apulse(1'b0, 1'b0, 1'b1);
    read_word(w);
    chk(w === pat(9'h1A5), "R3 second increment", int'(w), int'(pat(9'h1A5)));

    load_addr(511);
    read_word(w);
    chk(w === pat(511), "R2 serial address 511", int'(w), int'(pat(511)));
    apulse(1'b0, 1'b0, 1'b1);
    read_word(w);
    chk(w === pat(0), "R3 wrap 511 to 0", int'(w), int'(pat(0)));

    // R4: wiggle address controls with the address clock stopped
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #2;
      addr_shift_en = 1'(i & 1); addr_sdi = 1'((i >> 1) & 1);
    end
    read_word(w);
    chk(w === pat(0), "R4 address frozen without clock", int'(w), int'(pat(0)));

    // R6: zero fill after the word is exhausted
    for (int i = 0; i < 6; i++) begin
      dpulse(1'b1, 1'b1);
      chk(data_sdo === 1'b0, "R6 zero fill", int'(data_sdo), 0);
    end

    // R7: hold with data clock stopped
    load_addr(9'h0C6);
    dpulse(1'b0, 1'b1);
    dpulse(1'b1, 1'b1);
    dpulse(1'b1, 1'b1);
    held = pat(9'h0C6)[13];
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #2 data_load_n = 1'(i & 1);
    end
    @(negedge clk); #1;
    chk(data_sdo === held, "R7 hold without data clock", int'(data_sdo), int'(held));

    // R5: reload mid-shift restarts at bit 15
    dpulse(1'b1, 1'b1);
    dpulse(1'b0, 1'b1);
    chk(data_sdo === pat(9'h0C6)[15], "R5 reload mid-shift", int'(data_sdo), int'(pat(9'h0C6)[15]));

    // R8: rewrite one word and read it back
    init_write(7, 16'hBEEF);
    @(posedge clk); #2 init_we = 1'b0;
    load_addr(7);
    read_word(w);
    chk(w === 16'hBEEF, "R8 init rewrite", int'(w), 16'hBEEF);

    // R6: pattern with only end bits set
    init_write(8, 16'h8001);
    @(posedge clk); #2 init_we = 1'b0;
    apulse(1'b0, 1'b0, 1'b1);
    read_word(w);
    chk(w === 16'h8001, "R6 end bits", int'(w), 16'h8001);

    @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule